// File: doc/BRIEF.md
# Pseudo-SRAM Mixed-Mode Command Decoder

This block is the pin-level front end of a pseudo-static RAM running in a flash-like mode. In this mode array writes are decoded straight from the control pin levels, with no clock involved. Reads are clock-synchronous: a burst is opened on a rising edge and then streamed one word per edge. The block also loads two configuration words, one for the bus and one for refresh, from the address lines. It drives per-lane data output enables and a power-mode status code. It sequences deep power-down entry and the timed wake-up that follows.

The storage array sits outside the block and is reached through a plain write strobe, lane mask, address, write data and a combinational read-data return. The memory pins carry no valid/ready handshake and no back-pressure. Every command is accepted in the cycle it is presented, or dropped when the block is powered down or waking. A controller driving the pins must therefore follow the pin timing itself and cannot stall the block.

Top module: `psram_cmd_front`

## Requirements
- R1: After reset the bus configuration word is 16'h8000 (bit 15 = 1 selects the plain SRAM mode) and the refresh configuration word is 16'h0010. `rdy` is 1, `dq_oe` is 2'b00, and `pwr_mode` is 0 (standby) while `cs_n` is high.
- R2: A rising edge with `cs_n`=0, `we_n`=0 and `cre`=1 loads `addr[15:0]` into a configuration word. `addr[19]`=1 selects the bus word and `addr[19]`=0 selects the refresh word. No array write is raised.
- R3: With `cs_n`=0, `we_n`=0 and `cre`=0, `arr_we` rises combinationally in the same cycle, without waiting for a clock edge. In that cycle `arr_addr`=`addr`, `arr_wdata`=`dq_in` and `arr_wbe`={~`ub_n`,~`lb_n`} (bit 1 covers data bits 15..8). `oe_n` is ignored and `dq_oe` stays 2'b00.
- R4: The flash-like burst read exists only while bus configuration bit 15 is 0. With that bit set, clock edges with `adv_n` low start no burst, and the bus stays undriven.
- R5: A rising edge with `cs_n`=0, `adv_n`=0, `we_n`=1 and `cre`=0 opens a burst at `addr`. That edge drives no data.
- R6: Each later edge with `cs_n`=0, `adv_n`=1, `we_n`=1 and at least one byte enable low is a burst read. The n-th such edge (n from 0) places the word at start address + n on `dq_out`. `dq_oe` bit 1 follows ~`ub_n` and bit 0 follows ~`lb_n`, and both are gated by `oe_n` low.
- R7: During an open burst, an edge with both `ub_n` and `lb_n` high acts as deselect. The bus becomes undriven and the word pointer does not advance.
- R8: `cs_n` high forces `dq_oe` to 2'b00 at once and closes the burst. Edges with `adv_n` high then drive nothing until a new burst is opened.
- R9: Deep power-down is entered at the first edge with `cs_n` high while refresh configuration bit 4 is 0. It reports `pwr_mode`=2 and `rdy`=0 and blocks array writes. It persists until a register load writes the refresh word with bit 4 = 1.
- R10: After that load `pwr_mode` is 3 and `rdy` stays 0 for exactly CLK_MHZ*WAKE_US clock cycles (30000 by default, i.e. 150 us at 200 MHz). Every command, register loads included, is ignored during this time.
- R11: `pwr_mode` is 0 (standby) whenever `cs_n` is high. It is also 0 for an idle cycle with `cs_n` low whose address equals the address of the previous cycle, provided that cycle reported standby. Any other idle cycle, and every command cycle, reports 1 (active).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| adv_n | input | 1 | Address valid, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| ub_n | input | 1 | Upper byte enable (bits 15..8), active low |
| lb_n | input | 1 | Lower byte enable (bits 7..0), active low |
| cre | input | 1 | Configuration-register access select |
| addr | input | AW | Address, also configuration data source |
| dq_in | input | 16 | Write data from the pins |
| dq_out | output | 16 | Read data toward the pins |
| dq_oe | output | 2 | Per-lane output enable, bit 1 upper lane |
| arr_we | output | 1 | Array write strobe |
| arr_wbe | output | 2 | Array write lane mask |
| arr_addr | output | AW | Array address |
| arr_wdata | output | 16 | Array write data |
| arr_rdata | input | 16 | Array read data, combinational on arr_addr |
| cfg_ref | output | 16 | Refresh configuration word |
| cfg_bus | output | 16 | Bus configuration word |
| rdy | output | 1 | Normal operation allowed |
| pwr_mode | output | 2 | 0 standby, 1 active, 2 deep power-down, 3 waking |

## Verification
The assertions take it for granted that the pins change only away from the rising clock edge. They also assume `addr` and `dq_in` are steady for the whole cycle in which a write or register load is held. The bench meets both by changing every input one nanosecond after an edge and holding it for the full cycle. It keeps byte enables, address and data constant while `we_n` is low. The write-path checks rely on the array being purely combinational on reads, which the bench's memory model supplies.

// File: rtl/psram_pkg.sv
package psram_pkg;

  typedef enum logic [2:0] {
    C_DESEL,
    C_NOP,
    C_WRITE,
    C_REGSET,
    C_BINIT,
    C_BREAD,
    C_BHOLD
  } cmd_e;

  typedef enum logic [1:0] {
    PM_STBY = 2'd0,
    PM_ACT  = 2'd1,
    PM_DPD  = 2'd2,
    PM_WAKE = 2'd3
  } pmode_e;

  typedef enum logic [1:0] {
    S_RUN,
    S_DPD,
    S_WAKE
  } pst_e;

endpackage

// File: rtl/psram_cmd_decode.sv
module psram_cmd_decode
  import psram_pkg::*;
(
  input  logic cs_n,
  input  logic adv_n,
  input  logic we_n,
  input  logic ub_n,
  input  logic lb_n,
  input  logic cre,
  input  logic flash_mode,
  input  logic burst_open,
  input  logic rdy,
  input  logic in_dpd,
  output cmd_e cmd
);

  always_comb begin
    cmd = C_NOP;
    if (cs_n) begin
      cmd = C_DESEL;
    end else if (!we_n) begin
      // level-decoded write path; no clock edge or address strobe needed
      if (cre) cmd = (rdy || in_dpd) ? C_REGSET : C_NOP;
      else     cmd = rdy ? C_WRITE : C_NOP;
    end else if (!rdy) begin
      cmd = C_NOP;
    end else if (flash_mode && !cre && !adv_n) begin
      cmd = C_BINIT;
    end else if (flash_mode && adv_n && burst_open) begin
      cmd = (ub_n && lb_n) ? C_BHOLD : C_BREAD;
    end
  end

endmodule

// File: rtl/psram_cfg_regs.sv
module psram_cfg_regs #(
  parameter int          CW        = 16,
  parameter logic [15:0] REF_RESET = 16'h0010,
  parameter logic [15:0] BUS_RESET = 16'h8000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic          sel_bus,
  input  logic [CW-1:0] din,
  output logic [CW-1:0] ref_q,
  output logic [CW-1:0] bus_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= CW'(REF_RESET);
      bus_q <= CW'(BUS_RESET);
    end else if (ld) begin
      if (sel_bus) bus_q <= din;
      else         ref_q <= din;
    end
  end

  // R2: configuration words only change on a register load
  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> ($stable(ref_q) && $stable(bus_q)));

  // R2: a load lands in exactly the selected word
  p_cfg_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && sel_bus) |=> (bus_q == $past(din)) && $stable(ref_q));

endmodule

// File: rtl/psram_pwr_seq.sv
module psram_pwr_seq
  import psram_pkg::*;
#(
  parameter int AW       = 21,
  parameter int WAKE_CYC = 30000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic [AW-1:0] addr,
  input  cmd_e          cmd,
  input  logic          dpd_armed,
  input  logic          exit_req,
  output logic          rdy,
  output logic          in_dpd,
  output pmode_e        pmode
);

  localparam int CNTW = $clog2(WAKE_CYC + 1);

  pst_e            st;
  logic [CNTW-1:0] cnt;
  logic            stby_q;
  logic [AW-1:0]   addr_q;
  logic            idle;
  logic            stby_now;

  assign idle     = (cmd == C_NOP) || (cmd == C_BHOLD);
  assign stby_now = cs_n || (idle && stby_q && (addr == addr_q));
  assign rdy      = (st == S_RUN);
  assign in_dpd   = (st == S_DPD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_RUN;
      cnt <= '0;
    end else begin
      unique case (st)
        S_RUN:  if (cs_n && dpd_armed) st <= S_DPD;
        S_DPD:  if (exit_req) begin
                  st  <= S_WAKE;
                  cnt <= CNTW'(WAKE_CYC - 1);
                end
        S_WAKE: if (cnt == '0) st <= S_RUN;
                else           cnt <= cnt - 1'b1;
        default: st <= S_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stby_q <= 1'b1;
      addr_q <= '0;
    end else begin
      stby_q <= stby_now;
      addr_q <= addr;
    end
  end

  always_comb begin
    unique case (st)
      S_DPD:   pmode = PM_DPD;
      S_WAKE:  pmode = PM_WAKE;
      default: pmode = stby_now ? PM_STBY : PM_ACT;
    endcase
  end

  // R9: deep power-down is only left through the register exit request
  p_dpd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DPD && !exit_req) |=> (st == S_DPD));

  // R10: the wake counter steps down by one per cycle while waking
  p_wake_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAKE && cnt != '0) |=> (st == S_WAKE) && (cnt == $past(cnt) - 1'b1));

  // R10: expiry returns to normal operation
  p_wake_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAKE && cnt == '0) |=> (st == S_RUN));

  // R11: deselect while running always reports standby
  p_stby_desel_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && st == S_RUN) |-> (pmode == PM_STBY));

endmodule

// File: rtl/psram_burst_rd.sv
module psram_burst_rd
  import psram_pkg::*;
#(
  parameter int AW = 21,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cmd_e          cmd,
  input  logic [AW-1:0] addr,
  input  logic          ub_n,
  input  logic          lb_n,
  input  logic [DW-1:0] rdata,
  output logic [AW-1:0] ptr,
  output logic          open,
  output logic [DW-1:0] dout,
  output logic [1:0]    lane_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr    <= '0;
      open   <= 1'b0;
      dout   <= '0;
      lane_q <= 2'b00;
    end else begin
      unique case (cmd)
        C_BINIT: begin
          ptr    <= addr;
          open   <= 1'b1;
          lane_q <= 2'b00;
        end
        C_BREAD: begin
          dout   <= rdata;
          ptr    <= ptr + 1'b1;
          lane_q <= {~ub_n, ~lb_n};
        end
        C_DESEL, C_WRITE, C_REGSET: begin
          open   <= 1'b0;
          lane_q <= 2'b00;
        end
        default: lane_q <= 2'b00;
      endcase
    end
  end

  // R6: every burst read advances the word pointer by one
  p_ptr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_BREAD) |=> (ptr == $past(ptr) + 1'b1));

  // R7: both byte enables high in a burst freezes the pointer and drives nothing
  p_bhold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_BHOLD) |=> ($stable(ptr) && lane_q == 2'b00));

  // R8: deselect closes the burst
  p_desel_close_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_DESEL) |=> (!open && lane_q == 2'b00));

  // R5: opening a burst drives no data
  p_binit_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_BINIT) |=> (open && lane_q == 2'b00));

endmodule

// File: rtl/psram_cmd_front.sv
module psram_cmd_front
  import psram_pkg::*;
#(
  parameter int AW          = 21,
  parameter int CLK_MHZ     = 200,
  parameter int WAKE_US     = 150,
  parameter int REG_SEL_BIT = 19,
  parameter int DPD_BIT     = 4,
  parameter int MODE_BIT    = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          adv_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic          ub_n,
  input  logic          lb_n,
  input  logic          cre,
  input  logic [AW-1:0] addr,
  input  logic [15:0]   dq_in,
  output logic [15:0]   dq_out,
  output logic [1:0]    dq_oe,
  output logic          arr_we,
  output logic [1:0]    arr_wbe,
  output logic [AW-1:0] arr_addr,
  output logic [15:0]   arr_wdata,
  input  logic [15:0]   arr_rdata,
  output logic [15:0]   cfg_ref,
  output logic [15:0]   cfg_bus,
  output logic          rdy,
  output logic [1:0]    pwr_mode
);

  localparam int DW       = 16;
  localparam int CW       = 16;
  localparam int WAKE_CYC = CLK_MHZ * WAKE_US;

  cmd_e          cmd;
  logic          flash_mode;
  logic          burst_open;
  logic          in_dpd;
  logic          exit_req;
  logic [AW-1:0] ptr;
  logic [1:0]    lane_q;
  pmode_e        pmode;

  assign flash_mode = ~cfg_bus[MODE_BIT];
  assign exit_req   = (cmd == C_REGSET) && !addr[REG_SEL_BIT] && addr[DPD_BIT];

  psram_cmd_decode u_dec (
    .cs_n       (cs_n),
    .adv_n      (adv_n),
    .we_n       (we_n),
    .ub_n       (ub_n),
    .lb_n       (lb_n),
    .cre        (cre),
    .flash_mode (flash_mode),
    .burst_open (burst_open),
    .rdy        (rdy),
    .in_dpd     (in_dpd),
    .cmd        (cmd)
  );

  psram_cfg_regs #(.CW(CW)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld      (cmd == C_REGSET),
    .sel_bus (addr[REG_SEL_BIT]),
    .din     (addr[CW-1:0]),
    .ref_q   (cfg_ref),
    .bus_q   (cfg_bus)
  );

  psram_pwr_seq #(.AW(AW), .WAKE_CYC(WAKE_CYC)) u_pwr (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .addr      (addr),
    .cmd       (cmd),
    .dpd_armed (~cfg_ref[DPD_BIT]),
    .exit_req  (exit_req),
    .rdy       (rdy),
    .in_dpd    (in_dpd),
    .pmode     (pmode)
  );

  psram_burst_rd #(.AW(AW), .DW(DW)) u_burst (
    .clk    (clk),
    .rst_n  (rst_n),
    .cmd    (cmd),
    .addr   (addr),
    .ub_n   (ub_n),
    .lb_n   (lb_n),
    .rdata  (arr_rdata),
    .ptr    (ptr),
    .open   (burst_open),
    .dout   (dq_out),
    .lane_q (lane_q)
  );

  // asynchronous write path straight from the pin levels
  assign arr_we    = (cmd == C_WRITE);
  assign arr_wbe   = {~ub_n, ~lb_n};
  assign arr_wdata = dq_in;
  assign arr_addr  = arr_we ? addr : ptr;

  // lanes drive only while selected, reading and output-enabled
  assign dq_oe    = lane_q & {~ub_n, ~lb_n} & {2{~oe_n & we_n & ~cs_n}};
  assign pwr_mode = pmode;

  // R3: an array write never coincides with the bus being driven
  p_write_hiz_r3: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> (dq_oe == 2'b00));

  // R9: no array write while powered down
  p_dpd_nowrite_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_dpd |-> !arr_we);

  // R4: no burst data path in plain SRAM mode
  p_sram_noburst_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!flash_mode && $stable(cfg_bus)) |=> (lane_q == 2'b00));

endmodule

// File: tb/tb_psram_cmd_front.sv
module tb_psram_cmd_front;

  localparam int AW       = 21;
  localparam int WAKE_CYC = 200 * 150;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cs_n, adv_n, we_n, oe_n, ub_n, lb_n, cre;
  logic [AW-1:0] addr;
  logic [15:0]   dq_in, dq_out, arr_wdata, arr_rdata;
  logic [1:0]    dq_oe, arr_wbe, pwr_mode;
  logic          arr_we, rdy;
  logic [AW-1:0] arr_addr;
  logic [15:0]   cfg_ref, cfg_bus;
  logic [15:0]   mem [0:255];

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  psram_cmd_front dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .adv_n(adv_n), .we_n(we_n),
    .oe_n(oe_n), .ub_n(ub_n), .lb_n(lb_n), .cre(cre), .addr(addr),
    .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe), .arr_we(arr_we),
    .arr_wbe(arr_wbe), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
    .arr_rdata(arr_rdata), .cfg_ref(cfg_ref), .cfg_bus(cfg_bus),
    .rdy(rdy), .pwr_mode(pwr_mode)
  );

  function automatic logic [15:0] pat(input int a);
    return {8'(a) ^ 8'h5A, 8'(a)};
  endfunction

  // array model: combinational read, lane-masked write on the clock
  assign arr_rdata = mem[arr_addr[7:0]];
  always @(posedge clk) begin
    if (arr_we) begin
      if (arr_wbe[1]) mem[arr_addr[7:0]][15:8] <= arr_wdata[15:8];
      if (arr_wbe[0]) mem[arr_addr[7:0]][7:0]  <= arr_wdata[7:0];
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_pins();
    cs_n = 1; adv_n = 1; we_n = 1; oe_n = 1; ub_n = 0; lb_n = 0; cre = 0;
    addr = '0; dq_in = '0;
  endtask

  task automatic t_reset();
    rst_n = 0;
    idle_pins();
    repeat (3) step();
    rst_n = 1;
    step();
    chk("R1 bus cfg", 32'(cfg_bus), 32'h8000);
    chk("R1 ref cfg", 32'(cfg_ref), 32'h0010);
    chk("R1 rdy", 32'(rdy), 1);
    chk("R1 dq_oe", 32'(dq_oe), 0);
    chk("R1 pwr_mode", 32'(pwr_mode), 0);
  endtask

  task automatic t_sram_mode();
    cs_n = 0; adv_n = 0; oe_n = 0; addr = 21'h10;
    step();
    adv_n = 1;
    step();
    chk("R4 no burst in sram mode", 32'(dq_oe), 0);
    step();
    chk("R4 still undriven", 32'(dq_oe), 0);
    idle_pins();
    step();
  endtask

  task automatic t_regset();
    cs_n = 0; we_n = 0; cre = 1; addr = (21'h1 << 19) | 21'h0000;
    #1;
    chk("R2 no array write", 32'(arr_we), 0);
    step();
    chk("R2 bus word loaded", 32'(cfg_bus), 32'h0000);
    chk("R2 ref word kept", 32'(cfg_ref), 32'h0010);
    addr = 21'h0013;
    step();
    chk("R2 ref word loaded", 32'(cfg_ref), 32'h0013);
    chk("R2 bus word kept", 32'(cfg_bus), 32'h0000);
    idle_pins();
    step();
  endtask

  task automatic t_write();
    cs_n = 0; we_n = 0; oe_n = 0; ub_n = 0; lb_n = 1; addr = 21'h20; dq_in = 16'hBEEF;
    #1;
    chk("R3 async strobe", 32'(arr_we), 1);
    chk("R3 address", 32'(arr_addr), 32'h20);
    chk("R3 data", 32'(arr_wdata), 32'hBEEF);
    chk("R3 lane mask", 32'(arr_wbe), 32'b10);
    chk("R3 oe ignored", 32'(dq_oe), 0);
    step();
    idle_pins();
    step();
  endtask

  task automatic t_burst();
    logic [15:0] w20;
    w20 = {8'hBE, pat(32'h20)[7:0]};
    cs_n = 0; adv_n = 0; oe_n = 0; addr = 21'h1E;
    step();
    chk("R5 init drives nothing", 32'(dq_oe), 0);
    adv_n = 1; addr = 21'h3FF;
    step();
    chk("R6 word 0", 32'(dq_out), 32'(pat(32'h1E)));
    chk("R6 both lanes", 32'(dq_oe), 32'b11);
    step();
    chk("R6 word 1", 32'(dq_out), 32'(pat(32'h1F)));
    step();
    chk("R6 word 2 after lane write", 32'(dq_out), 32'(w20));
    step();
    chk("R6 word 3", 32'(dq_out), 32'(pat(32'h21)));
    lb_n = 1;
    step();
    chk("R6 upper lane only data", 32'(dq_out), 32'(pat(32'h22)));
    chk("R6 upper lane only oe", 32'(dq_oe), 32'b10);
    ub_n = 1;
    step();
    chk("R7 hold undriven", 32'(dq_oe), 0);
    ub_n = 0; lb_n = 0;
    step();
    chk("R7 no advance", 32'(dq_out), 32'(pat(32'h23)));
    chk("R6 oe lanes back", 32'(dq_oe), 32'b11);
    oe_n = 1;
    #1;
    chk("R6 oe gating", 32'(dq_oe), 0);
    oe_n = 0;
    cs_n = 1;
    #1;
    chk("R8 immediate hi-z", 32'(dq_oe), 0);
    step();
    cs_n = 0;
    step();
    chk("R8 closed burst", 32'(dq_oe), 0);
    step();
    chk("R8 closed burst stays", 32'(dq_oe), 0);
    idle_pins();
    step();
  endtask

  task automatic t_power();
    cs_n = 1; addr = 21'h55;
    step();
    chk("R11 deselect standby", 32'(pwr_mode), 0);
    cs_n = 0;
    #1;
    chk("R11 nop same addr standby", 32'(pwr_mode), 0);
    step();
    chk("R11 standby held", 32'(pwr_mode), 0);
    addr = 21'h56;
    #1;
    chk("R11 addr change active", 32'(pwr_mode), 1);
    step();
    addr = 21'h55;
    #1;
    chk("R11 stays active", 32'(pwr_mode), 1);
    adv_n = 0;
    #1;
    chk("R11 command active", 32'(pwr_mode), 1);
    idle_pins();
    #1;
    chk("R11 deselect again standby", 32'(pwr_mode), 0);
    step();
  endtask

  task automatic t_dpd();
    cs_n = 0; we_n = 0; cre = 1; addr = 21'h0000;
    step();
    chk("R9 ref bit4 cleared", 32'(cfg_ref), 0);
    idle_pins();
    step();
    chk("R9 in power-down", 32'(pwr_mode), 2);
    chk("R9 not ready", 32'(rdy), 0);
    cs_n = 0; we_n = 0; addr = 21'h30; dq_in = 16'h1234;
    #1;
    chk("R9 write blocked", 32'(arr_we), 0);
    step();
    idle_pins();
    step();
    chk("R9 sticky", 32'(pwr_mode), 2);
    cs_n = 0; we_n = 0; cre = 1; addr = 21'h0010;
    step();
    chk("R10 waking", 32'(pwr_mode), 3);
    chk("R10 ref restored", 32'(cfg_ref), 32'h0010);
    addr = (21'h1 << 19) | 21'h8000;
    step();
    idle_pins();
    for (int i = 0; i < WAKE_CYC - 2; i++) step();
    chk("R10 still not ready at last wake cycle", 32'(rdy), 0);
    chk("R10 still waking", 32'(pwr_mode), 3);
    step();
    chk("R10 ready after delay", 32'(rdy), 1);
    chk("R10 standby after wake", 32'(pwr_mode), 0);
    chk("R10 load during wake ignored", 32'(cfg_bus), 32'h0000);
    chk("R9 array untouched", 32'(mem[8'h30]), 32'(pat(32'h30)));
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = pat(i);
    t_reset();
    t_sram_mode();
    t_regset();
    t_write();
    t_burst();
    t_power();
    t_dpd();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule